// File: doc/BRIEF.md
# Stereo Sample Input Buffer

This block sits in front of a two-channel delta-sigma audio converter and feeds it one sample pair per sample period. Left and right 16-bit words are written through separate valid/ready ports, by a processor or a DMA engine, and each channel keeps them in its own four-entry first-in first-out store. A single sample strobe takes one word from each channel in the same cycle, so the two channels always stay in step. Each word is recoded into the offset-binary form the modulator expects and held on the output until the next strobe.

When a channel has no stored word at a strobe, it presents a programmable fallback word for that period instead. This keeps the converter at a known, safe level, usually midscale or zero, rather than repeating stale data or stalling. A format input selects whether incoming words, and the fallback word, are read as two's complement or as unsigned values.

Back-pressure rules: `x_in_ready` is high whenever the channel holds fewer than four words, and a word is taken on any rising edge where valid and ready are both high. The write port has no hold-off. A word presented while ready is low is discarded and recorded in a sticky overflow flag, so a source must watch ready itself. The output side cannot be stalled. `out_valid` marks a fresh pair for exactly one cycle.

Top module: `stereo_sample_buffer`

## Requirements
- R1: Each channel stores up to 4 words in arrival order. `fifo_empty` is high with 0 words stored, `fifo_full` is high with 4 words stored, and `x_in_ready` equals the inverse of that channel's full flag. Bit 0 of every two-bit status vector is left and bit 1 is right.
- R2: A valid word offered to a full channel is dropped and leaves the stored words unchanged. It sets that channel's `ovf_sticky` bit, which stays set until a 1 is written to the same bit of `ovf_clr`. A new drop in the same cycle as a clear keeps the bit set.
- R3: On a rising edge with `sample_tick` high, both channels remove their oldest word in the same cycle. The new codes and `out_valid` appear after that edge, and `out_valid` is high for exactly the one cycle following each strobe.
- R4: A channel that is empty at a strobe outputs the fallback word, recoded under the current format, with its `out_dflt` bit set. Its store stays empty, and the other channel is unaffected.
- R5: With `fmt_signed` = 0, the output code equals the input word (0xFFFF highest, 0x8000 midscale, 0x0000 lowest).
- R6: With `fmt_signed` = 1, the output code is the input word with bit 15 inverted, so 0x7FFF→0xFFFF, 0x0000→0x8000, 0xFFFF→0x7FFF and 0x8000→0x0000.
- R7: The fallback word is loaded from `dflt_wdata` when `dflt_we` is high, resets to 0x8000, and is recoded with the format in force at the strobe. A load in the same cycle as a strobe affects only later strobes.
- R8: After reset, both stores are empty, no overflow is flagged, `out_valid` and `out_dflt` are 0, and both output codes are 0x8000.
- R9: A write and a strobe in the same cycle on an empty channel output the fallback word and store the written word for the next strobe.
- R10: Output codes and `out_dflt` stay constant in every cycle that follows an edge without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_signed | input | 1 | 1: two's complement input, 0: unsigned input |
| dflt_we | input | 1 | Load the fallback word |
| dflt_wdata | input | 16 | Fallback word value |
| l_in_valid | input | 1 | Left write valid |
| l_in_data | input | 16 | Left sample word |
| l_in_ready | output | 1 | Left store can accept a word |
| r_in_valid | input | 1 | Right write valid |
| r_in_data | input | 16 | Right sample word |
| r_in_ready | output | 1 | Right store can accept a word |
| sample_tick | input | 1 | Sample strobe, pops both channels |
| ovf_clr | input | 2 | Write-one-to-clear for overflow flags |
| l_out_code | output | 16 | Left offset-binary code |
| r_out_code | output | 16 | Right offset-binary code |
| out_valid | output | 1 | New code pair present, one cycle |
| out_dflt | output | 2 | Fallback used for this pair, per channel |
| fifo_full | output | 2 | Store holds 4 words, per channel |
| fifo_empty | output | 2 | Store holds no word, per channel |
| ovf_sticky | output | 2 | Sticky overflow, per channel |

## Verification
All results are due one edge after their cause. A write shows in the full, empty and ready flags after the edge that takes it. A strobe produces its code pair and `out_valid` after the edge on which it is high, and an overflow or clear changes its flag after that same edge. The bench drives each stimulus for exactly one cycle. It updates its reference model at the rising edge that consumes the stimulus and compares flags and queued expected code pairs at the following falling edge, before the next stimulus. Between strobes it compares the outputs with the last expected pair, which checks that they hold.

// File: rtl/stereo_buf_pkg.sv
package stereo_buf_pkg;
  localparam int SAMPLE_W   = 16;
  localparam int FIFO_DEPTH = 4;
  localparam int NUM_CH     = 2;

  typedef enum logic [0:0] {CH_LEFT = 1'b0, CH_RIGHT = 1'b1} chan_e;
endpackage

// File: rtl/sbuf_fifo.sv
module sbuf_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          push_ok, pop_ok;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = mem[rd_ptr];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= nxt(wr_ptr);
      if (pop_ok)  rd_ptr <= nxt(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/sbuf_lane.sv
module sbuf_lane #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fmt_signed,
  input  logic [W-1:0] dflt_word,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         in_ready,
  input  logic         tick,
  input  logic         ovf_clr,
  output logic [W-1:0] out_code,
  output logic         out_dflt,
  output logic         full,
  output logic         empty,
  output logic         ovf
);
  localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] head, pick;
  logic         drop;

  sbuf_fifo #(.W(W), .DEPTH(DEPTH)) fifo_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (in_valid),
    .push_data (in_data),
    .pop       (tick),
    .head      (head),
    .full      (full),
    .empty     (empty)
  );

  assign in_ready = !full;
  assign drop     = in_valid && full;
  assign pick     = empty ? dflt_word : head;

  function automatic logic [W-1:0] to_code(input logic [W-1:0] d, input logic sgn);
    return sgn ? {~d[W-1], d[W-2:0]} : d;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf      <= 1'b0;
      out_code <= MID;
      out_dflt <= 1'b0;
    end else begin
      if (drop)         ovf <= 1'b1;
      else if (ovf_clr) ovf <= 1'b0;
      if (tick) begin
        out_code <= to_code(pick, fmt_signed);
        out_dflt <= empty;
      end
    end
  end
endmodule

// File: rtl/stereo_sample_buffer.sv
module stereo_sample_buffer
  import stereo_buf_pkg::*;
#(
  parameter int W     = SAMPLE_W,
  parameter int DEPTH = FIFO_DEPTH
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fmt_signed,
  input  logic         dflt_we,
  input  logic [W-1:0] dflt_wdata,
  input  logic         l_in_valid,
  input  logic [W-1:0] l_in_data,
  output logic         l_in_ready,
  input  logic         r_in_valid,
  input  logic [W-1:0] r_in_data,
  output logic         r_in_ready,
  input  logic         sample_tick,
  input  logic [1:0]   ovf_clr,
  output logic [W-1:0] l_out_code,
  output logic [W-1:0] r_out_code,
  output logic         out_valid,
  output logic [1:0]   out_dflt,
  output logic [1:0]   fifo_full,
  output logic [1:0]   fifo_empty,
  output logic [1:0]   ovf_sticky
);
  localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] dflt_q;
  logic         vld   [NUM_CH];
  logic [W-1:0] data  [NUM_CH];
  logic         rdy   [NUM_CH];
  logic [W-1:0] code  [NUM_CH];

  assign vld[CH_LEFT]   = l_in_valid;
  assign vld[CH_RIGHT]  = r_in_valid;
  assign data[CH_LEFT]  = l_in_data;
  assign data[CH_RIGHT] = r_in_data;
  assign l_in_ready     = rdy[CH_LEFT];
  assign r_in_ready     = rdy[CH_RIGHT];
  assign l_out_code     = code[CH_LEFT];
  assign r_out_code     = code[CH_RIGHT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dflt_q    <= MID;
      out_valid <= 1'b0;
    end else begin
      if (dflt_we) dflt_q <= dflt_wdata;
      out_valid <= sample_tick;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
    sbuf_lane #(.W(W), .DEPTH(DEPTH)) lane_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .fmt_signed (fmt_signed),
      .dflt_word  (dflt_q),
      .in_valid   (vld[c]),
      .in_data    (data[c]),
      .in_ready   (rdy[c]),
      .tick       (sample_tick),
      .ovf_clr    (ovf_clr[c]),
      .out_code   (code[c]),
      .out_dflt   (out_dflt[c]),
      .full       (fifo_full[c]),
      .empty      (fifo_empty[c]),
      .ovf        (ovf_sticky[c])
    );
  end
endmodule

// File: rtl/stereo_sample_buffer_chk.sv
module stereo_sample_buffer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        l_in_valid,
  input logic        l_in_ready,
  input logic        r_in_valid,
  input logic        r_in_ready,
  input logic        sample_tick,
  input logic [1:0]  ovf_clr,
  input logic [15:0] l_out_code,
  input logic [15:0] r_out_code,
  input logic        out_valid,
  input logic [1:0]  out_dflt,
  input logic [1:0]  fifo_full,
  input logic [1:0]  fifo_empty,
  input logic [1:0]  ovf_sticky
);
  assert_full_empty_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_full[0] && fifo_empty[0]) && !(fifo_full[1] && fifo_empty[1]));

  assert_ovf_cause_l_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_sticky[0]) |-> $past(l_in_valid && !l_in_ready));

  assert_ovf_cause_r_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_sticky[1]) |-> $past(r_in_valid && !r_in_ready));

  assert_ovf_hold_l_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_sticky[0] && !ovf_clr[0] |=> ovf_sticky[0]);

  assert_ovf_hold_r_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_sticky[1] && !ovf_clr[1] |=> ovf_sticky[1]);

  assert_valid_after_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tick |=> out_valid);

  assert_no_valid_without_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_tick |=> !out_valid);

  assert_dflt_flag_l_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tick && fifo_empty[0] |=> out_dflt[0]);

  assert_dflt_flag_r_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tick && fifo_empty[1] |=> out_dflt[1]);

  assert_stays_empty_l_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tick && fifo_empty[0] && !l_in_valid |=> fifo_empty[0]);

  assert_outputs_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_tick |=> $stable(l_out_code) && $stable(r_out_code) && $stable(out_dflt));
endmodule

bind stereo_sample_buffer stereo_sample_buffer_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .l_in_valid  (l_in_valid),
  .l_in_ready  (l_in_ready),
  .r_in_valid  (r_in_valid),
  .r_in_ready  (r_in_ready),
  .sample_tick (sample_tick),
  .ovf_clr     (ovf_clr),
  .l_out_code  (l_out_code),
  .r_out_code  (r_out_code),
  .out_valid   (out_valid),
  .out_dflt    (out_dflt),
  .fifo_full   (fifo_full),
  .fifo_empty  (fifo_empty),
  .ovf_sticky  (ovf_sticky)
);

// File: tb/stereo_sample_buffer_tb_top.sv
module stereo_sample_buffer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n, fmt_signed, dflt_we, l_in_valid, r_in_valid, sample_tick;
  logic [15:0] dflt_wdata, l_in_data, r_in_data;
  logic [1:0]  ovf_clr;
  logic        l_in_ready, r_in_ready, out_valid;
  logic [15:0] l_out_code, r_out_code;
  logic [1:0]  out_dflt, fifo_full, fifo_empty, ovf_sticky;

  always #10 clk = ~clk;

  stereo_sample_buffer dut_i (
    .clk(clk), .rst_n(rst_n), .fmt_signed(fmt_signed), .dflt_we(dflt_we),
    .dflt_wdata(dflt_wdata), .l_in_valid(l_in_valid), .l_in_data(l_in_data),
    .l_in_ready(l_in_ready), .r_in_valid(r_in_valid), .r_in_data(r_in_data),
    .r_in_ready(r_in_ready), .sample_tick(sample_tick), .ovf_clr(ovf_clr),
    .l_out_code(l_out_code), .r_out_code(r_out_code), .out_valid(out_valid),
    .out_dflt(out_dflt), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
    .ovf_sticky(ovf_sticky)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference model
  logic [15:0] mq_l[$];
  logic [15:0] mq_r[$];
  logic        movf_l = 0, movf_r = 0;
  logic [15:0] mdflt = 16'h8000;

  // scoreboard
  logic [15:0] exp_l[$];
  logic [15:0] exp_r[$];
  logic [1:0]  exp_df[$];
  string       exp_tag[$];
  logic [15:0] held_l = 16'h8000, held_r = 16'h8000;
  logic [1:0]  held_df = 2'b00;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  function automatic logic [15:0] conv(input logic [15:0] d, input logic sgn);
    return sgn ? (d ^ 16'h8000) : d;
  endfunction

  task automatic mdl_lane(ref logic [15:0] q[$], ref logic ovf, input logic v,
                          input logic [15:0] d, input logic clr, input logic tk,
                          output logic [15:0] code, output logic used);
    code = 16'h0;
    used = 1'b0;
    if (tk) begin
      if (q.size() == 0) begin
        code = conv(mdflt, fmt_signed);
        used = 1'b1;
      end else begin
        code = conv(q.pop_front(), fmt_signed);
      end
    end
    if (v) begin
      if (q.size() < 4) q.push_back(d);
      else ovf = 1'b1;
    end else if (clr) begin
      ovf = 1'b0;
    end
    if (v && q.size() < 4 && clr) ovf = 1'b0;
  endtask

  task automatic step(input logic lv, input logic [15:0] ld, input logic rv,
                      input logic [15:0] rd, input logic tk, input logic [1:0] clr,
                      input logic dwe, input logic [15:0] dwd, input string tag);
    logic [15:0] cl, cr;
    logic        ul, ur;
    bit          drop_l, drop_r;
    l_in_valid = lv; l_in_data = ld; r_in_valid = rv; r_in_data = rd;
    sample_tick = tk; ovf_clr = clr; dflt_we = dwe; dflt_wdata = dwd;
    @(posedge clk);
    drop_l = lv && (mq_l.size() == 4) && !(tk && 0);
    drop_r = rv && (mq_r.size() == 4);
    mdl_lane(mq_l, movf_l, lv, ld, clr[0] && !drop_l, tk, cl, ul);
    mdl_lane(mq_r, movf_r, rv, rd, clr[1] && !drop_r, tk, cr, ur);
    if (dwe) mdflt = dwd;
    if (tk) begin
      exp_l.push_back(cl);
      exp_r.push_back(cr);
      exp_df.push_back({ur, ul});
      exp_tag.push_back(tag);
    end
    @(negedge clk);
    chk(fifo_full  == {mq_r.size() == 4, mq_l.size() == 4}, "R1", "fifo_full",
        32'(fifo_full), 32'({mq_r.size() == 4, mq_l.size() == 4}));
    chk(fifo_empty == {mq_r.size() == 0, mq_l.size() == 0}, "R1", "fifo_empty",
        32'(fifo_empty), 32'({mq_r.size() == 0, mq_l.size() == 0}));
    chk({r_in_ready, l_in_ready} == {mq_r.size() < 4, mq_l.size() < 4}, "R1", "ready",
        32'({r_in_ready, l_in_ready}), 32'({mq_r.size() < 4, mq_l.size() < 4}));
    chk(ovf_sticky == {movf_r, movf_l}, "R2", "ovf_sticky",
        32'(ovf_sticky), 32'({movf_r, movf_l}));
    l_in_valid = 0; r_in_valid = 0; sample_tick = 0; ovf_clr = 0; dflt_we = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 2'b00, 0, 0, "R10");
  endtask

  task automatic tick(input string tag);
    step(0, 0, 0, 0, 1, 2'b00, 0, 0, tag);
    idle(1);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        if (exp_l.size() == 0) begin
          chk(0, "R3", "unexpected out_valid", 32'(out_valid), 32'(0));
        end else begin
          string t;
          held_l = exp_l.pop_front();
          held_r = exp_r.pop_front();
          held_df = exp_df.pop_front();
          t = exp_tag.pop_front();
          chk(l_out_code == held_l, t, "l_out_code", 32'(l_out_code), 32'(held_l));
          chk(r_out_code == held_r, t, "r_out_code", 32'(r_out_code), 32'(held_r));
          chk(out_dflt == held_df, t, "out_dflt", 32'(out_dflt), 32'(held_df));
        end
      end else begin
        chk(l_out_code == held_l && r_out_code == held_r && out_dflt == held_df,
            "R10", "held outputs", {l_out_code, r_out_code}, {held_l, held_r});
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 0; fmt_signed = 0; dflt_we = 0; dflt_wdata = 0;
    l_in_valid = 0; l_in_data = 0; r_in_valid = 0; r_in_data = 0;
    sample_tick = 0; ovf_clr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8 reset state
    chk(l_out_code == 16'h8000 && r_out_code == 16'h8000, "R8", "reset codes",
        {l_out_code, r_out_code}, 32'h80008000);
    chk(out_valid == 0 && out_dflt == 0, "R8", "reset valid/dflt",
        32'({out_valid, out_dflt}), 32'(0));
    chk(fifo_empty == 2'b11 && fifo_full == 2'b00 && ovf_sticky == 2'b00, "R8",
        "reset flags", 32'({fifo_empty, fifo_full, ovf_sticky}), 32'(6'b110000));
    rst_n = 1;

    // R1/R5: fill both channels, unsigned
    step(1, 16'hFFFF, 1, 16'h1234, 0, 2'b00, 0, 0, "R1");
    step(1, 16'h8000, 1, 16'h5678, 0, 2'b00, 0, 0, "R1");
    step(1, 16'h7FFF, 1, 16'h9ABC, 0, 2'b00, 0, 0, "R1");
    step(1, 16'h0000, 1, 16'hDEF0, 0, 2'b00, 0, 0, "R1");
    // R2: drop into full left
    step(1, 16'hAAAA, 0, 0, 0, 2'b00, 0, 0, "R2");
    idle(2);
    repeat (4) tick("R5");
    // R4: both empty -> fallback 0x8000
    tick("R4");
    // R2: clear, then refill and drop with simultaneous clear
    step(0, 0, 0, 0, 0, 2'b01, 0, 0, "R2");
    for (int i = 0; i < 4; i++) step(1, 16'(16'h0100 + i), 0, 0, 0, 2'b00, 0, 0, "R1");
    step(1, 16'hBBBB, 0, 0, 0, 2'b01, 0, 0, "R2");
    step(0, 0, 0, 0, 0, 2'b01, 0, 0, "R2");
    // R4: left data, right fallback
    repeat (4) tick("R4");
    // R7: signed mode, new fallback 0x0000 -> code 0x8000
    fmt_signed = 1;
    step(0, 0, 0, 0, 0, 2'b00, 1, 16'h0000, "R7");
    tick("R7");
    // R7: fallback load during strobe affects only later strobes
    step(0, 0, 0, 0, 1, 2'b00, 1, 16'h7FFF, "R7");
    tick("R7");
    // R6: signed words
    step(1, 16'h7FFF, 1, 16'h8000, 0, 2'b00, 0, 0, "R6");
    step(1, 16'h0000, 1, 16'hFFFF, 0, 2'b00, 0, 0, "R6");
    step(1, 16'hFFFF, 1, 16'h0000, 0, 2'b00, 0, 0, "R6");
    step(1, 16'h8000, 1, 16'h7FFF, 0, 2'b00, 0, 0, "R6");
    repeat (4) tick("R6");
    // R9: write and strobe together on empty channels
    fmt_signed = 0;
    step(1, 16'h1111, 1, 16'h2222, 1, 2'b00, 0, 0, "R9");
    idle(1);
    tick("R9");
    idle(3);
    chk(exp_l.size() == 0, "R3", "pending expected pairs", 32'(exp_l.size()), 32'(0));
    finish_run();
  end
endmodule